// File: doc/BRIEF.md
# Coincident-Current Core Plane Sequencer

This block runs the read and write cycles of a square magnetic core plane stack. Each bit of the word lives in its own plane, and every plane shares the same X and Y drive lines. A host request carries an address, a write flag and write data. The block splits the address into a row index, which picks one X line, and a column index, which picks one Y line. It then drives those two lines together, so only the core where they cross receives enough current to switch.

Reading a core destroys its contents. The block first drives the selected core toward 0. It samples the digitised sense input of each plane after a settle interval: a pulse means the core held 1. It then runs a set phase with the drive polarity reversed, which puts each value back. During that phase it asserts the per-plane inhibit wherever the latched bit was 0. A write uses the same two phases. The first phase clears the core and the sensed value is discarded. In the set phase, inhibit is asserted on every plane whose write bit is 0.

The durations of the clear phase, the settle interval and the set phase are all parameters counted in clock cycles.

Top module: `core_mem_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `reqReady` is 1 and all of `xSel`, `ySel`, `drivePol`, `inhibit` and `done` are 0.
- R2: During a drive phase exactly one X line and exactly one Y line are active. The X index is the upper ROW_W address bits (bits 11..6 by default) and the Y index is the lower COL_W bits (bits 5..0). No line is active outside the drive phases, and the selection does not change within a phase.
- R3: Every request starts with a clear phase. It lasts DRIVE_CYC cycles with `drivePol` = 0 (0 means the clear direction). `sense` is latched at the end of the SETTLE_CYC-th cycle of that phase, and the latched value is returned on `rdData`.
- R4: A read restores the value it senses, so a second read of the same address returns the same word.
- R5: A write runs the clear phase and then a set phase of REWRITE_CYC cycles with `drivePol` = 1 (1 means the set direction). A later read returns the written word, and this includes bits that change from 1 to 0.
- R6: `inhibit` is nonzero only during a set phase. In a set phase it equals the inverse of the write data for a write, or the inverse of the latched sense word for a read.
- R7: Between the clear phase and the set phase there is at least one cycle with every select line inactive. `drivePol` never changes while a select line stays active from one cycle to the next.
- R8: `reqReady` is 1 only when the block is idle. A request is taken on a clock edge where both `reqValid` and `reqReady` are 1. A request raised while the block is busy has no effect.
- R9: `done` is a one-cycle pulse DRIVE_CYC+REWRITE_CYC+2 cycles after the accepting edge, with `rdData` valid in that cycle. The block is ready again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request strobe |
| reqReady | output | 1 | Block is idle and can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ROW_W+COL_W | Word address: row in the upper bits, column in the lower bits |
| reqWData | input | WORD_W | Write data, one bit per plane |
| rdData | output | WORD_W | Sensed word, valid while done is 1 |
| done | output | 1 | One-cycle completion pulse |
| xSel | output | 2**ROW_W | One-hot X drive line select |
| ySel | output | 2**COL_W | One-hot Y drive line select |
| drivePol | output | 1 | Drive direction: 0 = clear, 1 = set |
| inhibit | output | WORD_W | Per-plane block of the set pulse |
| sense | input | WORD_W | Digitised sense pulse, one per plane |

## Verification
The bench attaches a behavioural core array that clears a core and pulses sense at the start of a clear drive, and sets the unmasked bits during a set drive. A controller that skipped the restore phase, or used the wrong polarity in it, would return zeros on the second read of an address. Rewriting a word of ones as all zeros targets a block that only ORs bits in, because that block would leave the old ones in place. The corner addresses 0x000 and 0xFFF, together with single-row and single-column patterns, expose a decode that swaps the row and column fields or shifts them. A request raised mid-cycle toward an address that holds data shows whether a busy block wrongly accepts it, since the stored word would then be destroyed.

// File: rtl/core_mem_pkg.sv
package core_mem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CLEAR,
    PH_GAP,
    PH_SET,
    PH_DONE
  } phase_e;

  typedef struct packed {
    logic accept;      // take a new request
    logic latchSense;  // capture the sense word
    logic driveOn;     // select lines active
    logic setPhase;    // set-direction drive
  } strobe_t;
endpackage

// File: rtl/core_mem_seq.sv
module core_mem_seq
  import core_mem_pkg::*;
#(
  parameter int DRIVE_CYC   = 40,
  parameter int SETTLE_CYC  = 25,
  parameter int REWRITE_CYC = 40
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  output logic    done,
  output strobe_t strobe
);
  localparam int MAX_CYC = (DRIVE_CYC > REWRITE_CYC) ? DRIVE_CYC : REWRITE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  phase_e     phase;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          cnt <= '0;
          if (reqValid) phase <= PH_CLEAR;
        end
        PH_CLEAR: begin
          if (cnt == CNT_W'(DRIVE_CYC - 1)) begin
            cnt   <= '0;
            phase <= PH_GAP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_GAP: phase <= PH_SET;
        PH_SET: begin
          if (cnt == CNT_W'(REWRITE_CYC - 1)) begin
            cnt   <= '0;
            phase <= PH_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DONE: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.accept     = (phase == PH_IDLE) && reqValid;
    strobe.latchSense = (phase == PH_CLEAR) && (cnt == CNT_W'(SETTLE_CYC - 1));
    strobe.driveOn    = (phase == PH_CLEAR) || (phase == PH_SET);
    strobe.setPhase   = (phase == PH_SET);
    reqReady          = (phase == PH_IDLE);
    done              = (phase == PH_DONE);
  end
endmodule

// File: rtl/core_mem_path.sv
module core_mem_path
  import core_mem_pkg::*;
#(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 6,
  parameter int WORD_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobe_t                strobe,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [WORD_W-1:0]      reqWData,
  input  logic [WORD_W-1:0]      sense,
  output logic [WORD_W-1:0]      rdData,
  output logic [(1<<ROW_W)-1:0]  xSel,
  output logic [(1<<COL_W)-1:0]  ySel,
  output logic                   drivePol,
  output logic [WORD_W-1:0]      inhibit
);
  localparam int ROWS = 1 << ROW_W;
  localparam int COLS = 1 << COL_W;

  logic [ROW_W-1:0]  rowQ;
  logic [COL_W-1:0]  colQ;
  logic              writeQ;
  logic [WORD_W-1:0] wdataQ;
  logic [WORD_W-1:0] senseQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ   <= '0;
      colQ   <= '0;
      writeQ <= 1'b0;
      wdataQ <= '0;
      senseQ <= '0;
    end else begin
      if (strobe.accept) begin
        rowQ   <= reqAddr[ROW_W+COL_W-1:COL_W];
        colQ   <= reqAddr[COL_W-1:0];
        writeQ <= reqWrite;
        wdataQ <= reqWData;
      end
      if (strobe.latchSense) senseQ <= sense;
    end
  end

  // One driver per line; only the latched index fires during a drive phase.
  for (genvar r = 0; r < ROWS; r++) begin : g_xDrv
    assign xSel[r] = strobe.driveOn && (rowQ == ROW_W'(r));
  end
  for (genvar c = 0; c < COLS; c++) begin : g_yDrv
    assign ySel[c] = strobe.driveOn && (colQ == COL_W'(c));
  end

  assign drivePol = strobe.setPhase;
  assign inhibit  = strobe.setPhase ? (writeQ ? ~wdataQ : ~senseQ) : '0;
  assign rdData   = senseQ;
endmodule

// File: rtl/core_mem_ctrl.sv
module core_mem_ctrl
  import core_mem_pkg::*;
#(
  parameter int ROW_W       = 6,
  parameter int COL_W       = 6,
  parameter int WORD_W      = 8,
  parameter int DRIVE_CYC   = 40,
  parameter int SETTLE_CYC  = 25,
  parameter int REWRITE_CYC = 40
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [WORD_W-1:0]      reqWData,
  output logic [WORD_W-1:0]      rdData,
  output logic                   done,
  output logic [(1<<ROW_W)-1:0]  xSel,
  output logic [(1<<COL_W)-1:0]  ySel,
  output logic                   drivePol,
  output logic [WORD_W-1:0]      inhibit,
  input  logic [WORD_W-1:0]      sense
);
  strobe_t strobe;

  core_mem_seq #(
    .DRIVE_CYC(DRIVE_CYC), .SETTLE_CYC(SETTLE_CYC), .REWRITE_CYC(REWRITE_CYC)
  ) u_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .reqReady(reqReady), .done(done), .strobe(strobe)
  );

  core_mem_path #(
    .ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWData(reqWData), .sense(sense), .rdData(rdData),
    .xSel(xSel), .ySel(ySel), .drivePol(drivePol), .inhibit(inhibit)
  );
endmodule

// File: rtl/core_mem_chk.sv
module core_mem_chk #(
  parameter int ROW_W  = 6,
  parameter int COL_W  = 6,
  parameter int WORD_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  reqReady,
  input logic                  done,
  input logic [(1<<ROW_W)-1:0] xSel,
  input logic [(1<<COL_W)-1:0] ySel,
  input logic                  drivePol,
  input logic [WORD_W-1:0]     inhibit
);
  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(xSel) && $onehot0(ySel) && ((xSel != '0) == (ySel != '0)));

  // R2
  sel_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((xSel != '0) && ($past(xSel) != '0)) |-> ($stable(xSel) && $stable(ySel)));

  // R7
  pol_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((xSel != '0) && ($past(xSel) != '0)) |-> $stable(drivePol));

  // R6
  inhibit_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inhibit != '0) |-> (drivePol && (xSel != '0)));

  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> ((xSel == '0) && !done && !drivePol));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));
endmodule

bind core_mem_ctrl core_mem_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .done(done),
  .xSel(xSel), .ySel(ySel), .drivePol(drivePol), .inhibit(inhibit)
);

// File: tb/tb_core_mem_ctrl.sv
`timescale 1ns/1ps
module tb_core_mem_ctrl;
  localparam int ROW_W = 6, COL_W = 6, WORD_W = 8;
  localparam int DRV = 6, SETL = 3, RW = 5;
  localparam int AW = ROW_W + COL_W;
  localparam int LAT = DRV + RW + 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [WORD_W-1:0] reqWData = '0, sense;
  logic reqReady, done, drivePol;
  logic [WORD_W-1:0] rdData, inhibit;
  logic [(1<<ROW_W)-1:0] xSel;
  logic [(1<<COL_W)-1:0] ySel;

  always #2.5 clk = ~clk;

  core_mem_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W),
    .DRIVE_CYC(DRV), .SETTLE_CYC(SETL), .REWRITE_CYC(RW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWData(reqWData),
    .rdData(rdData), .done(done), .xSel(xSel), .ySel(ySel),
    .drivePol(drivePol), .inhibit(inhibit), .sense(sense));

  // Behavioural core array
  logic [WORD_W-1:0] coreArr [0:(1<<AW)-1];
  logic [WORD_W-1:0] senseDrv = '0;
  logic wasActive = 1'b0;
  assign sense = senseDrv;

  function automatic int hotIdx(input logic [63:0] v);
    int r = 0;
    for (int i = 0; i < 64; i++) if (v[i]) r = i;
    return r;
  endfunction

  always @(posedge clk) begin
    int a;
    a = hotIdx(64'(xSel)) * (1 << COL_W) + hotIdx(64'(ySel));
    if (xSel != '0 && ySel != '0) begin
      if (!drivePol && !wasActive) begin
        senseDrv <= coreArr[a];
        coreArr[a] <= '0;
      end else if (drivePol) begin
        coreArr[a] <= coreArr[a] | ~inhibit;
      end
    end else begin
      senseDrv <= '0;
    end
    wasActive <= (xSel != '0);
  end

  int nTests = 0, nFail = 0;
  int clrCyc = 0, setCyc = 0, badSel = 0, badPol = 0, badInh = 0;
  logic [AW-1:0] curAddr = '0;
  logic [WORD_W-1:0] expInh = '0;
  logic prevAct = 1'b0, prevPol = 1'b0;

  // Port monitor, sampled mid-cycle
  always @(negedge clk) if (rstN) begin
    logic act;
    act = (xSel != '0);
    if (act) begin
      if (xSel != ((1<<ROW_W)'(1) << curAddr[AW-1:COL_W]) ||
          ySel != ((1<<COL_W)'(1) << curAddr[COL_W-1:0])) badSel++;
      if (drivePol) setCyc++; else clrCyc++;
      if (prevAct && drivePol != prevPol) badPol++;
      if (drivePol && inhibit != expInh) badInh++;
    end else if (ySel != '0) badSel++;
    if (!(act && drivePol) && inhibit != '0) badInh++;
    prevAct = act;
    prevPol = drivePol;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One request; busyPoke raises a stray write mid-cycle.
  task automatic runOp(input bit wr, input logic [AW-1:0] addr,
                       input logic [WORD_W-1:0] data, input logic [WORD_W-1:0] exp,
                       input bit busyPoke);
    int c0, s0, bs, bp, bi, lat;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    c0 = clrCyc; s0 = setCyc; bs = badSel; bp = badPol; bi = badInh;
    curAddr = addr;
    expInh = wr ? ~data : ~exp;
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWData = data;
    @(negedge clk);
    lat = 1;
    reqValid = 1'b0;
    while (!done && lat < 100) begin
      if (busyPoke && lat == 3) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = '0; reqWData = '0;
        check(reqReady == 1'b0, "R8", "ready low while busy", reqReady, 0);
      end
      if (busyPoke && lat == 8) reqValid = 1'b0;
      @(negedge clk);
      lat++;
    end
    reqValid = 1'b0;
    check(lat == LAT, "R9", "done latency", lat, LAT);
    if (!wr) check(rdData == exp, "R3/R4/R5", "read word", rdData, exp);
    check(clrCyc - c0 == DRV, "R3", "clear phase length", clrCyc - c0, DRV);
    check(setCyc - s0 == RW, "R5", "set phase length", setCyc - s0, RW);
    check(badSel == bs, "R2", "select decode errors", badSel - bs, 0);
    check(badPol == bp, "R7", "polarity change while selected", badPol - bp, 0);
    check(badInh == bi, "R6", "inhibit mismatches", badInh - bi, 0);
    @(negedge clk);
    check(!done && reqReady, "R9", "done one cycle then ready", {done, reqReady}, 1);
  endtask

  typedef struct packed {
    logic wr;
    logic [AW-1:0] addr;
    logic [WORD_W-1:0] data;
    logic [WORD_W-1:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h000, 8'hA5, 8'h00},
    '{1'b1, 12'hFFF, 8'h3C, 8'h00},
    '{1'b0, 12'h000, 8'h00, 8'hA5},  // R3
    '{1'b0, 12'h000, 8'h00, 8'hA5},  // R4 restore
    '{1'b0, 12'hFFF, 8'h00, 8'h3C},
    '{1'b1, 12'h041, 8'hFF, 8'h00},
    '{1'b1, 12'h041, 8'h00, 8'h00},  // R5 ones to zeros
    '{1'b0, 12'h041, 8'h00, 8'h00},
    '{1'b0, 12'h042, 8'h00, 8'h00},
    '{1'b1, 12'h7C0, 8'h5A, 8'h00},
    '{1'b0, 12'h7C0, 8'h00, 8'h5A},
    '{1'b0, 12'hFFF, 8'h00, 8'h3C}
  };

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d expected <150000", cycles);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) coreArr[i] = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(reqReady && xSel == '0 && ySel == '0 && !drivePol && inhibit == '0 && !done,
          "R1", "outputs in reset", {reqReady, done, drivePol}, 4);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && xSel == '0 && !done && inhibit == '0, "R1", "idle after reset",
          {reqReady, done}, 2);
    for (int i = 0; i < NV; i++)
      runOp(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].exp, 1'b0);
    // R8 stray request while busy must not wipe 0x000
    runOp(1'b0, 12'h123, 8'h00, 8'h00, 1'b1);
    runOp(1'b0, 12'h000, 8'h00, 8'hA5, 1'b0);
    // R2 row/column fields are not swapped
    runOp(1'b1, 12'h03F, 8'h81, 8'h00, 1'b0);
    runOp(1'b0, 12'hFC0, 8'h00, 8'h00, 1'b0);
    runOp(1'b0, 12'h03F, 8'h00, 8'h81, 1'b0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule